// File: doc/BRIEF.md
# Prescaled 13-bit Timer/Counter

This block holds one timer register pair, a high byte and a low byte, and runs it as a 13-bit counter. The count is formed by the full high byte above the five low bits of the low byte. The three upper bits of the low byte are storage only. Counting never changes them. Each counting event adds one. When the five low bits roll over, they carry into the high byte. When the count moves from 1FFFh to 0000h, that is an overflow.

Counting events come from one of two places. In timer mode they come from a free-running prescaler: the system clock divided by 4, 64 or 1024, or falling edges of a slow sub-clock that is synchronised into the system clock domain. In counter mode they are falling edges on an external count pin, also synchronised. Counting is allowed only when the run control is set and the gate condition passes. Software can write either byte at any time. An overflow is held until the next machine-cycle sample strobe, and only then is it moved into the overflow flag. Software clears the flag with a strobe.

Top module: `tmr13_unit`

## Requirements
- R1: While reset is asserted and directly after it, th_o, tl_o and ovf_flag_o are all zero.
- R2: The count is {th_o, tl_o[4:0]}. Counting never changes tl_o[7:5]; only a low-byte write changes them.
- R3: Each counting event adds one to the 13-bit count. When tl_o[4:0] steps from 1Fh to 00h, th_o also increments. After 1FFFh the count becomes 0000h, and this is an overflow.
- R4: In timer mode, clk_sel_i chooses the event source. 0 selects the clock divided by 4, 1 the clock divided by 64, 2 the clock divided by 1024, and 3 the falling edges of sub_clk_i, taken after a two-flop synchroniser. The divider starts at zero on reset and runs freely.
- R5: Events are counted only when run_i is 1 and either gate_i is 0 or int_pin_i is 1. Otherwise the count holds.
- R6: When ct_sel_i is 1, the block counts falling edges of cnt_pin_i, taken after a two-flop synchroniser. In this mode clk_sel_i and sub_clk_i have no effect.
- R7: A write strobe loads wdata_i into its byte at the next clock edge. The write takes priority over a count event on that same edge.
- R8: An overflow sets ovf_flag_o only on a clock edge where mc_sample_i is 1. An overflow seen while mc_sample_i is 0 is held until the next sample.
- R9: Any number of overflows between two samples produce a single flag set. Overflows that are already reported are not raised again after a clear. flag_clr_i clears the flag, and a set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_sample_i | input | 1 | Machine-cycle sample strobe for the overflow |
| run_i | input | 1 | Run control |
| gate_i | input | 1 | When 1, counting also needs int_pin_i |
| ct_sel_i | input | 1 | 0 = timer mode, 1 = count-pin mode |
| int_pin_i | input | 1 | External interrupt pin level, used by the gate |
| cnt_pin_i | input | 1 | External count pin |
| sub_clk_i | input | 1 | Sub-oscillator clock |
| clk_sel_i | input | 2 | Timer event source select |
| wr_hi_i | input | 1 | High-byte write strobe |
| wr_lo_i | input | 1 | Low-byte write strobe |
| wdata_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| th_o | output | 8 | High byte |
| tl_o | output | 8 | Low byte |
| ovf_flag_o | output | 1 | Overflow flag |

## Verification
The following are checked on every cycle:
- the count moves by at most one step without a write;
- the upper low-byte bits are unaffected by counting;
- the count holds while run is low;
- writes land on the next edge;
- the flag rises only after a sample strobe;
- a clear without a sample always drops the flag.

Only the bench's scenarios can show:
- the divide ratios of each source;
- gating by the interrupt pin;
- edge counting through the synchronisers;
- the exact rollover values;
- two held overflows merging into one reported flag.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;
   typedef enum logic [1:0] {
      SRC_DIV_A = 2'd0,
      SRC_DIV_B = 2'd1,
      SRC_DIV_C = 2'd2,
      SRC_SUB   = 2'd3
   } tmr_src_e;
endpackage

// File: rtl/tmr13_fall_det.sv
module tmr13_fall_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tmr13_fall_det: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr13_presc.sv
module tmr13_presc
   import tmr13_pkg::*;
#(
   parameter int TAP_A = 2,
   parameter int TAP_B = 6,
   parameter int TAP_C = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       sub_tick,
   output logic       tick
);
   localparam int PRE_W = TAP_C;
   localparam int NTAP  = 3;

   generate
      if (!(TAP_A > 0 && TAP_A < TAP_B && TAP_B < TAP_C)) begin : g_bad
         $error("tmr13_presc: taps must be strictly increasing and positive");
      end
   endgenerate

   logic [PRE_W-1:0] div_q;
   logic [NTAP-1:0]  tap_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   generate
      for (genvar i = 0; i < NTAP; i++) begin : g_tap
         localparam int W = (i == 0) ? TAP_A : (i == 1) ? TAP_B : TAP_C;
         assign tap_hit[i] = &div_q[W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (tmr_src_e'(sel))
         SRC_DIV_A: tick = tap_hit[0];
         SRC_DIV_B: tick = tap_hit[1];
         SRC_DIV_C: tick = tap_hit[2];
         SRC_SUB:   tick = sub_tick;
         default:   tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr13_core.sv
module tmr13_core #(
   parameter int DATA_W   = 8,
   parameter int LO_CNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] th,
   output logic [DATA_W-1:0] tl,
   output logic              ovf_pulse
);
   generate
      if (LO_CNT_W < 1 || LO_CNT_W > DATA_W) begin : g_bad
         $error("tmr13_core: LO_CNT_W out of range");
      end
   endgenerate

   logic [LO_CNT_W-1:0] lo_cnt;
   logic                lo_max;
   logic                hi_max;

   assign lo_cnt    = tl[LO_CNT_W-1:0];
   assign lo_max    = &lo_cnt;
   assign hi_max    = &th;
   assign ovf_pulse = inc & lo_max & hi_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tl <= '0;
      end else if (wr_lo) begin
         tl <= wdata;
      end else if (inc) begin
         tl[LO_CNT_W-1:0] <= lo_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         th <= '0;
      end else if (wr_hi) begin
         th <= wdata;
      end else if (inc && lo_max) begin
         th <= th + 1'b1;
      end
   end
endmodule

// File: rtl/tmr13_ovf_cap.sv
module tmr13_ovf_cap (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_pulse,
   input  logic sample,
   input  logic clr,
   output logic flag
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (sample)    pend_q <= 1'b0;
      else if (ovf_pulse) pend_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                             flag <= 1'b0;
      else if (sample && (pend_q || ovf_pulse)) flag <= 1'b1;
      else if (clr)                           flag <= 1'b0;
   end
endmodule

// File: rtl/tmr13_unit.sv
module tmr13_unit #(
   parameter int DATA_W      = 8,
   parameter int LO_CNT_W    = 5,
   parameter int SYNC_STAGES = 2,
   parameter int TAP_A       = 2,
   parameter int TAP_B       = 6,
   parameter int TAP_C       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_sample_i,
   input  logic              run_i,
   input  logic              gate_i,
   input  logic              ct_sel_i,
   input  logic              int_pin_i,
   input  logic              cnt_pin_i,
   input  logic              sub_clk_i,
   input  logic [1:0]        clk_sel_i,
   input  logic              wr_hi_i,
   input  logic              wr_lo_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              flag_clr_i,
   output logic [DATA_W-1:0] th_o,
   output logic [DATA_W-1:0] tl_o,
   output logic              ovf_flag_o
);
   logic sub_fall, pin_fall, pre_tick, evt, cnt_en, inc, ovf_pulse;

   tmr13_fall_det #(.STAGES(SYNC_STAGES)) u_sub_sync (
      .clk(clk), .rst_n(rst_n), .din(sub_clk_i), .fall(sub_fall)
   );

   tmr13_fall_det #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .din(cnt_pin_i), .fall(pin_fall)
   );

   tmr13_presc #(.TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C)) u_presc (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel_i), .sub_tick(sub_fall), .tick(pre_tick)
   );

   assign evt    = ct_sel_i ? pin_fall : pre_tick;
   assign cnt_en = run_i & (~gate_i | int_pin_i);
   assign inc    = cnt_en & evt;

   tmr13_core #(.DATA_W(DATA_W), .LO_CNT_W(LO_CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .inc(inc), .wr_hi(wr_hi_i), .wr_lo(wr_lo_i),
      .wdata(wdata_i), .th(th_o), .tl(tl_o), .ovf_pulse(ovf_pulse)
   );

   tmr13_ovf_cap u_cap (
      .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .sample(mc_sample_i),
      .clr(flag_clr_i), .flag(ovf_flag_o)
   );
endmodule

// File: rtl/tmr13_chk.sv
module tmr13_chk #(
   parameter int DATA_W   = 8,
   parameter int LO_CNT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mc_sample_i,
   input logic              run_i,
   input logic              wr_hi_i,
   input logic              wr_lo_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              flag_clr_i,
   input logic [DATA_W-1:0] th_o,
   input logic [DATA_W-1:0] tl_o,
   input logic              ovf_flag_o
);
   localparam int CNT_W = DATA_W + LO_CNT_W;
   logic [CNT_W-1:0] cnt;
   assign cnt = {th_o, tl_o[LO_CNT_W-1:0]};

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo_i && !wr_hi_i) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R3

   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo_i |=> tl_o[DATA_W-1:LO_CNT_W] == $past(tl_o[DATA_W-1:LO_CNT_W])); // R2

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable({th_o, tl_o})); // R5

   AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> tl_o == $past(wdata_i)); // R7

   AST_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi_i |=> th_o == $past(wdata_i)); // R7

   AST_SET_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag_o) |-> $past(mc_sample_i)); // R8

   AST_CLEAR_WINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !mc_sample_i) |=> !ovf_flag_o); // R9
endmodule

bind tmr13_unit tmr13_chk #(.DATA_W(DATA_W), .LO_CNT_W(LO_CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mc_sample_i(mc_sample_i), .run_i(run_i),
   .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wdata_i(wdata_i), .flag_clr_i(flag_clr_i),
   .th_o(th_o), .tl_o(tl_o), .ovf_flag_o(ovf_flag_o)
);

// File: tb/tmr13_unit_tb.sv
module tmr13_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_sample_i = 1'b1;
   logic       run_i = 1'b0, gate_i = 1'b0, ct_sel_i = 1'b0, int_pin_i = 1'b0;
   logic       cnt_pin_i = 1'b0, sub_clk_i = 1'b0;
   logic [1:0] clk_sel_i = 2'd0;
   logic       wr_hi_i = 1'b0, wr_lo_i = 1'b0, flag_clr_i = 1'b0;
   logic [7:0] wdata_i = 8'h00;
   logic [7:0] th_o, tl_o;
   logic       ovf_flag_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   tmr13_unit u_dut (
      .clk(clk), .rst_n(rst_n), .mc_sample_i(mc_sample_i), .run_i(run_i),
      .gate_i(gate_i), .ct_sel_i(ct_sel_i), .int_pin_i(int_pin_i),
      .cnt_pin_i(cnt_pin_i), .sub_clk_i(sub_clk_i), .clk_sel_i(clk_sel_i),
      .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wdata_i(wdata_i),
      .flag_clr_i(flag_clr_i), .th_o(th_o), .tl_o(tl_o), .ovf_flag_o(ovf_flag_o)
   );

   // sel, run, gate, intp, pre_hi, pre_lo, edges
   localparam logic [36:0] VEC [8] = '{
      {2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 16'd40},
      {2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 16'd40},
      {2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 16'd40},
      {2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 16'd40},
      {2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 16'd200},
      {2'd0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFE, 16'd12},
      {2'd0, 1'b1, 1'b0, 1'b0, 8'h12, 8'h1F, 16'd4},
      {2'd2, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 16'd2100}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      run_i = 1'b0; gate_i = 1'b0; ct_sel_i = 1'b0; int_pin_i = 1'b0;
      cnt_pin_i = 1'b0; sub_clk_i = 1'b0; clk_sel_i = 2'd0;
      wr_hi_i = 1'b0; wr_lo_i = 1'b0; flag_clr_i = 1'b0; mc_sample_i = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_byte(input bit hi, input logic [7:0] val);
      wdata_i = val;
      if (hi) wr_hi_i = 1'b1; else wr_lo_i = 1'b1;
      @(negedge clk);
      wr_hi_i = 1'b0; wr_lo_i = 1'b0;
   endtask

   task automatic sub_fall();
      sub_clk_i = 1'b1;
      repeat (3) @(negedge clk);
      sub_clk_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pin_fall();
      cnt_pin_i = 1'b1;
      repeat (3) @(negedge clk);
      cnt_pin_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_sample(input bit with_clr);
      mc_sample_i = 1'b1; flag_clr_i = with_clr;
      @(negedge clk);
      mc_sample_i = 1'b0; flag_clr_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      check("R1", "th", th_o, 0);
      check("R1", "tl", tl_o, 0);
      check("R1", "flag", ovf_flag_o, 0);

      // Table walk: R2 R3 R4 R5 R8
      for (int v = 0; v < 8; v++) begin
         logic [1:0] sel;
         logic       run, gate, intp;
         logic [7:0] phi, plo;
         int         n, period, incs, sum, nw;
         {sel, run, gate, intp, phi, plo} = VEC[v][36:16];
         n = int'(VEC[v][15:0]);
         do_reset();
         clk_sel_i = sel; run_i = run; gate_i = gate; int_pin_i = intp;
         wr_byte(1'b1, phi);
         wr_byte(1'b0, plo);
         repeat (n - 2) @(negedge clk);
         run_i = 1'b0;
         repeat (8) @(negedge clk);
         period = (sel == 2'd0) ? 4 : (sel == 2'd1) ? 64 : 1024;
         incs = (run && (!gate || intp)) ? n / period : 0;
         sum = int'({phi, plo[4:0]}) + incs;
         nw = sum % 8192;
         check("R3/R4/R5", $sformatf("vec%0d th", v), th_o, (nw >> 5) & 8'hFF);
         check("R2/R3", $sformatf("vec%0d tl", v), tl_o, (plo & 8'hE0) | (nw & 8'h1F));
         check("R8", $sformatf("vec%0d flag", v), ovf_flag_o, (sum >= 8192) ? 1 : 0);
      end

      // R4: sub-clock source, five falls
      do_reset();
      clk_sel_i = 2'd3; run_i = 1'b1;
      repeat (5) sub_fall();
      check("R4", "sub-clock count", tl_o, 5);

      // R6: count-pin mode ignores prescaler and sub-clock
      do_reset();
      clk_sel_i = 2'd0; ct_sel_i = 1'b1; run_i = 1'b1;
      repeat (6) pin_fall();
      repeat (3) sub_fall();
      check("R6", "pin count", tl_o, 6);

      // R7: write wins over the tick on the same edge
      do_reset();
      clk_sel_i = 2'd0; run_i = 1'b1;
      repeat (3) @(negedge clk);
      wr_byte(1'b0, 8'h5A);
      check("R7", "write vs tick", tl_o, 8'h5A);
      repeat (4) @(negedge clk);
      check("R7", "count after write", tl_o, 8'h5B);

      // R8 / R9: held, merged and cleared overflows
      do_reset();
      clk_sel_i = 2'd3; run_i = 1'b1; mc_sample_i = 1'b0;
      wr_byte(1'b1, 8'hFF); wr_byte(1'b0, 8'h1F);
      sub_fall();
      check("R3", "wrap count", {th_o, tl_o}, 0);
      check("R8", "no flag before sample", ovf_flag_o, 0);
      wr_byte(1'b1, 8'hFF); wr_byte(1'b0, 8'h1F);
      sub_fall();
      pulse_sample(1'b0);
      check("R8", "flag after sample", ovf_flag_o, 1);
      flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
      check("R9", "flag cleared", ovf_flag_o, 0);
      pulse_sample(1'b0);
      check("R9", "second overflow merged", ovf_flag_o, 0);
      wr_byte(1'b1, 8'hFF); wr_byte(1'b0, 8'h1F);
      sub_fall();
      pulse_sample(1'b1);
      check("R9", "set beats clear", ovf_flag_o, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule